// File: doc/BRIEF.md
# Maskable BCD Calendar Alarm Matcher

This block watches a running calendar kept in BCD and compares it with a programmed alarm word each time the calendar advances by one second. When every field that takes part in the comparison agrees, a sticky alarm flag is set. The flag stays set until software writes a zero to it. An interrupt line is driven from the flag, gated by an interrupt enable.

The alarm word packs four fields: seconds, minutes, hours with a PM marker, and a day field. Each field has its own mask bit. A set mask bit removes that field from the comparison. The day field holds either a BCD day of the month or a weekday code, chosen by a select bit. Month and year are never compared, so with the day masked the alarm fires once per day. The calendar can run in 24-hour or 12-hour format, and the hour comparison follows that format.

Top module: `bcd_alarm_matcher`

## Requirements
- R1: After reset `alarmFlag` and `alarmIrq` are 0.
- R2: In the cycle after a `secTick` pulse, with `alarmEn` high and all unmasked fields equal, `alarmFlag` is 1. Without a tick the flag does not set, even when the fields are equal.
- R3: Alarm bits 6:0 hold BCD seconds, compared with `calSec`. When bit 7 is set the seconds are ignored; otherwise a seconds mismatch prevents the match.
- R4: Alarm bits 14:8 hold BCD minutes, compared with `calMin`. When bit 15 is set the minutes are ignored.
- R5: Alarm bits 21:16 hold BCD hours, compared with `calHour`, and bit 23 masks the hours. With `twelveHour` low, a set PM bit (bit 22) prevents an hour match.
- R6: With `twelveHour` high, the PM bit (bit 22) must equal `calPm` for an hour match.
- R7: When bit 31 is set the day field is ignored, and any date or weekday matches.
- R8: With bit 30 clear, bits 29:24 hold a BCD day of month compared with `calDate`. With bit 30 set, bits 27:24 hold a weekday code compared with `{1'b0, calWeekday}`, and the day of month is ignored.
- R9: While `alarmEn` is low, a tick with matching fields leaves `alarmFlag` at 0.
- R10: `alarmFlag` stays set until a write with `flagWrEn`=1 and `flagWrData`=0. That write clears it on the next edge. A write with `flagWrData`=1 has no effect.
- R11: `alarmIrq` is 1 only when `alarmFlag` and `irqEn` are both 1.
- R12: When a matching tick and a clearing write fall in the same cycle, the flag ends set.
- R13: Driving `alarmEn` low does not clear a flag that is already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-cycle pulse each calendar second |
| calSec | input | 7 | Calendar seconds, BCD |
| calMin | input | 7 | Calendar minutes, BCD |
| calHour | input | 6 | Calendar hours, BCD |
| calPm | input | 1 | Calendar PM state (12-hour format) |
| calDate | input | 6 | Calendar day of month, BCD |
| calWeekday | input | 3 | Calendar weekday code, 1 to 7 |
| twelveHour | input | 1 | 1 selects 12-hour format |
| alarmWord | input | 32 | Packed alarm fields and masks |
| alarmEn | input | 1 | Alarm comparison enable |
| irqEn | input | 1 | Alarm interrupt enable |
| flagWrEn | input | 1 | Write strobe for the alarm flag |
| flagWrData | input | 1 | Value written; 0 clears the flag |
| alarmFlag | output | 1 | Sticky alarm flag |
| alarmIrq | output | 1 | Alarm interrupt line |

## Verification
A matching second tick and a software write of zero to the flag can land in the same cycle. The bench provokes this by raising `secTick` and the clearing write on one falling edge. It does this once with the flag already set and a matching alarm, and once with a non-matching alarm. It judges the result from `alarmFlag` after the following rising edge: the matching case must leave the flag set, and the non-matching case must leave it cleared.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int AlarmW      = 32;
  localparam int FieldStride = 8;
  localparam int MsW         = 7;
  localparam int MsFields    = 2;
  localparam int HourLsb     = 16;
  localparam int HourW       = 6;
  localparam int PmBit       = 22;
  localparam int HourMaskBit = 23;
  localparam int DayLsb      = 24;
  localparam int DayW        = 6;
  localparam int WdayW       = 3;
  localparam int WdayFieldW  = WdayW + 1;
  localparam int WdSelBit    = 30;
  localparam int DayMaskBit  = 31;

  typedef struct packed {
    logic evalStb;
    logic clearStb;
  } alm_strobe_t;
endpackage

// File: rtl/alm_control.sv
module alm_control
  import alm_pkg::*;
(
  input  logic        secTick,
  input  logic        alarmEn,
  input  logic        flagWrEn,
  input  logic        flagWrData,
  output alm_strobe_t strobes
);
  // Comparison is only sampled on a second boundary while armed.
  always_comb begin
    strobes.evalStb  = secTick && alarmEn;
    strobes.clearStb = flagWrEn && !flagWrData;
  end
endmodule

// File: rtl/alm_datapath.sv
module alm_datapath
  import alm_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  alm_strobe_t         strobes,
  input  logic [AlarmW-1:0]   alarmWord,
  input  logic [MsW-1:0]      calSec,
  input  logic [MsW-1:0]      calMin,
  input  logic [HourW-1:0]    calHour,
  input  logic                calPm,
  input  logic [DayW-1:0]     calDate,
  input  logic [WdayW-1:0]    calWeekday,
  input  logic                twelveHour,
  output logic                matchNow,
  output logic                flagQ
);
  logic [MsW-1:0] calMs [MsFields];
  logic [MsFields-1:0] msHit;
  logic hourHit, pmOk, dayHit, dateHit, wdayHit;

  assign calMs[0] = calSec;
  assign calMs[1] = calMin;

  // Seconds and minutes share one layout: value then mask bit, 8 bits apart.
  for (genvar gi = 0; gi < MsFields; gi++) begin : g_ms
    logic [MsW-1:0] almVal;
    logic           almMask;
    assign almVal  = alarmWord[gi*FieldStride +: MsW];
    assign almMask = alarmWord[gi*FieldStride + MsW];
    assign msHit[gi] = almMask || (almVal == calMs[gi]);
  end

  always_comb begin
    pmOk    = twelveHour ? (alarmWord[PmBit] == calPm) : !alarmWord[PmBit];
    hourHit = alarmWord[HourMaskBit] ||
              ((alarmWord[HourLsb +: HourW] == calHour) && pmOk);
    dateHit = alarmWord[DayLsb +: DayW] == calDate;
    wdayHit = alarmWord[DayLsb +: WdayFieldW] == {1'b0, calWeekday};
    dayHit  = alarmWord[DayMaskBit] ||
              (alarmWord[WdSelBit] ? wdayHit : dateHit);
    matchNow = (&msHit) && hourHit && dayHit;
  end

  // A fresh event outranks a concurrent software clear.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (strobes.evalStb && matchNow) begin
      flagQ <= 1'b1;
    end else if (strobes.clearStb) begin
      flagQ <= 1'b0;
    end
  end
endmodule

// File: rtl/bcd_alarm_matcher.sv
module bcd_alarm_matcher
  import alm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic [MsW-1:0]    calSec,
  input  logic [MsW-1:0]    calMin,
  input  logic [HourW-1:0]  calHour,
  input  logic              calPm,
  input  logic [DayW-1:0]   calDate,
  input  logic [WdayW-1:0]  calWeekday,
  input  logic              twelveHour,
  input  logic [AlarmW-1:0] alarmWord,
  input  logic              alarmEn,
  input  logic              irqEn,
  input  logic              flagWrEn,
  input  logic              flagWrData,
  output logic              alarmFlag,
  output logic              alarmIrq
);
  alm_strobe_t strobes;
  logic matchNow;

  alm_control u_ctl (
    .secTick    (secTick),
    .alarmEn    (alarmEn),
    .flagWrEn   (flagWrEn),
    .flagWrData (flagWrData),
    .strobes    (strobes)
  );

  alm_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .alarmWord  (alarmWord),
    .calSec     (calSec),
    .calMin     (calMin),
    .calHour    (calHour),
    .calPm      (calPm),
    .calDate    (calDate),
    .calWeekday (calWeekday),
    .twelveHour (twelveHour),
    .matchNow   (matchNow),
    .flagQ      (alarmFlag)
  );

  assign alarmIrq = alarmFlag && irqEn;
endmodule

// File: rtl/alm_checker.sv
module alm_checker (
  input logic clk,
  input logic rstN,
  input logic secTick,
  input logic alarmEn,
  input logic irqEn,
  input logic flagWrEn,
  input logic flagWrData,
  input logic matchNow,
  input logic alarmFlag,
  input logic alarmIrq
);
  p_rise_needs_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmFlag) |-> $past(secTick && alarmEn && matchNow));

  p_disabled_no_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!alarmEn && !alarmFlag) |=> !alarmFlag);

  p_clear_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    (flagWrEn && !flagWrData && !secTick) |=> !alarmFlag);

  p_sticky_r13: assert property (@(posedge clk) disable iff (!rstN)
    (alarmFlag && !(flagWrEn && !flagWrData)) |=> alarmFlag);

  p_irq_needs_flag_r11: assert property (@(posedge clk) disable iff (!rstN)
    alarmIrq |-> (alarmFlag && irqEn));

  p_set_wins_r12: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && alarmEn && matchNow && flagWrEn) |=> alarmFlag);
endmodule

bind bcd_alarm_matcher alm_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .secTick    (secTick),
  .alarmEn    (alarmEn),
  .irqEn      (irqEn),
  .flagWrEn   (flagWrEn),
  .flagWrData (flagWrData),
  .matchNow   (matchNow),
  .alarmFlag  (alarmFlag),
  .alarmIrq   (alarmIrq)
);

// File: tb/sim_bcd_alarm_matcher.sv
`timescale 1ns/1ps
module sim_bcd_alarm_matcher;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic secTick = 1'b0;
  logic [6:0] calSec = 7'h56;
  logic [6:0] calMin = 7'h34;
  logic [5:0] calHour = 6'h12;
  logic calPm = 1'b0;
  logic [5:0] calDate = 6'h15;
  logic [2:0] calWeekday = 3'd3;
  logic twelveHour = 1'b0;
  logic [31:0] alarmWord = '0;
  logic alarmEn = 1'b0;
  logic irqEn = 1'b0;
  logic flagWrEn = 1'b0;
  logic flagWrData = 1'b0;
  logic alarmFlag, alarmIrq;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bcd_alarm_matcher u0 (
    .clk(clk), .rstN(rstN), .secTick(secTick), .calSec(calSec), .calMin(calMin),
    .calHour(calHour), .calPm(calPm), .calDate(calDate), .calWeekday(calWeekday),
    .twelveHour(twelveHour), .alarmWord(alarmWord), .alarmEn(alarmEn),
    .irqEn(irqEn), .flagWrEn(flagWrEn), .flagWrData(flagWrData),
    .alarmFlag(alarmFlag), .alarmIrq(alarmIrq)
  );

  function automatic logic [31:0] mkAlarm(input logic dm, input logic wd,
      input logic [5:0] day, input logic hm, input logic pm, input logic [5:0] hr,
      input logic mm, input logic [6:0] mn, input logic sm, input logic [6:0] sc);
    return {dm, wd, day, hm, pm, hr, mm, mn, sm, sc};
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // Pulse secTick for one cycle; flag result visible at the following negedge.
  task automatic tick();
    @(negedge clk) secTick = 1'b1;
    @(negedge clk) secTick = 1'b0;
  endtask

  task automatic clearFlag();
    @(negedge clk) begin flagWrEn = 1'b1; flagWrData = 1'b0; end
    @(negedge clk) flagWrEn = 1'b0;
  endtask

  task automatic defaultCal();
    calSec = 7'h56; calMin = 7'h34; calHour = 6'h12; calPm = 1'b0;
    calDate = 6'h15; calWeekday = 3'd3; twelveHour = 1'b0;
  endtask

  task automatic expectTick(input string req, input logic [31:0] aw, input logic exp);
    clearFlag();
    alarmWord = aw;
    tick();
    chk(req, alarmFlag, exp);
  endtask

  task automatic t_reset_r1();
    chk("R1 flag", alarmFlag, 1'b0);
    chk("R1 irq", alarmIrq, 1'b0);
  endtask

  task automatic t_full_match_r2();
    defaultCal(); alarmEn = 1'b1;
    clearFlag();
    alarmWord = mkAlarm(0,0,6'h15,0,0,6'h12,0,7'h34,0,7'h56);
    repeat (3) @(negedge clk);
    chk("R2 no tick no set", alarmFlag, 1'b0);
    tick();
    chk("R2 match sets", alarmFlag, 1'b1);
  endtask

  task automatic t_fields_r3_r8();
    defaultCal(); alarmEn = 1'b1;
    expectTick("R3 sec mismatch", mkAlarm(0,0,6'h15,0,0,6'h12,0,7'h34,0,7'h57), 1'b0);
    expectTick("R3 sec masked", mkAlarm(0,0,6'h15,0,0,6'h12,0,7'h34,1,7'h57), 1'b1);
    expectTick("R4 min mismatch", mkAlarm(0,0,6'h15,0,0,6'h12,0,7'h35,0,7'h56), 1'b0);
    expectTick("R4 min masked", mkAlarm(0,0,6'h15,0,0,6'h12,1,7'h35,0,7'h56), 1'b1);
    expectTick("R5 hour mismatch", mkAlarm(0,0,6'h15,0,0,6'h13,0,7'h34,0,7'h56), 1'b0);
    expectTick("R5 hour masked", mkAlarm(0,0,6'h15,1,0,6'h13,0,7'h34,0,7'h56), 1'b1);
    expectTick("R5 pm in 24h", mkAlarm(0,0,6'h15,0,1,6'h12,0,7'h34,0,7'h56), 1'b0);
    twelveHour = 1'b1; calHour = 6'h07; calPm = 1'b1;
    expectTick("R6 pm equal", mkAlarm(0,0,6'h15,0,1,6'h07,0,7'h34,0,7'h56), 1'b1);
    expectTick("R6 pm differs", mkAlarm(0,0,6'h15,0,0,6'h07,0,7'h34,0,7'h56), 1'b0);
    defaultCal();
    expectTick("R7 day mismatch", mkAlarm(0,0,6'h16,0,0,6'h12,0,7'h34,0,7'h56), 1'b0);
    expectTick("R7 day masked", mkAlarm(1,0,6'h16,0,0,6'h12,0,7'h34,0,7'h56), 1'b1);
    calDate = 6'h28;
    expectTick("R8 weekday hit", mkAlarm(0,1,6'h03,0,0,6'h12,0,7'h34,0,7'h56), 1'b1);
    expectTick("R8 weekday miss", mkAlarm(0,1,6'h05,0,0,6'h12,0,7'h34,0,7'h56), 1'b0);
    expectTick("R8 date mode", mkAlarm(0,0,6'h28,0,0,6'h12,0,7'h34,0,7'h56), 1'b1);
    defaultCal();
  endtask

  task automatic t_enable_r9();
    alarmEn = 1'b0;
    expectTick("R9 disabled", mkAlarm(1,0,0,1,0,0,1,0,1,0), 1'b0);
    alarmEn = 1'b1;
  endtask

  task automatic t_sticky_r10_r11_r13();
    irqEn = 1'b0;
    expectTick("R10 set", mkAlarm(1,0,0,1,0,0,1,0,1,0), 1'b1);
    chk("R11 irq gated", alarmIrq, 1'b0);
    @(negedge clk) irqEn = 1'b1;
    #1 chk("R11 irq on", alarmIrq, 1'b1);
    alarmWord = mkAlarm(0,0,6'h01,0,0,6'h01,0,7'h01,0,7'h01);
    tick();
    chk("R10 stays set", alarmFlag, 1'b1);
    @(negedge clk) alarmEn = 1'b0;
    repeat (2) @(negedge clk);
    chk("R13 enable off keeps flag", alarmFlag, 1'b1);
    alarmEn = 1'b1;
    @(negedge clk) begin flagWrEn = 1'b1; flagWrData = 1'b1; end
    @(negedge clk) flagWrEn = 1'b0;
    chk("R10 write one ignored", alarmFlag, 1'b1);
    clearFlag();
    chk("R10 write zero clears", alarmFlag, 1'b0);
    chk("R11 irq off", alarmIrq, 1'b0);
  endtask

  task automatic t_collision_r12();
    expectTick("R12 preset", mkAlarm(1,0,0,1,0,0,1,0,1,0), 1'b1);
    @(negedge clk) begin secTick = 1'b1; flagWrEn = 1'b1; flagWrData = 1'b0; end
    @(negedge clk) begin secTick = 1'b0; flagWrEn = 1'b0; end
    chk("R12 set wins", alarmFlag, 1'b1);
    alarmWord = mkAlarm(0,0,6'h01,0,0,6'h01,0,7'h01,0,7'h01);
    @(negedge clk) begin secTick = 1'b1; flagWrEn = 1'b1; flagWrData = 1'b0; end
    @(negedge clk) begin secTick = 1'b0; flagWrEn = 1'b0; end
    chk("R12 no match clears", alarmFlag, 1'b0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset_r1();
        rstN = 1'b1;
        t_full_match_r2();
        t_fields_r3_r8();
        t_enable_r9();
        t_sticky_r10_r11_r13();
        t_collision_r12();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule